// File: doc/BRIEF.md
# Serial Command Programming Sequencer

This block loads a 20-bit command into a front-end module over a serial link. A caller presents a 24-bit word and pulses a start input while serial mode is selected. Bits 23:20 of the word select the target channel, from 0 to 14, and the code 15 addresses all 15 channels at once. Bits 19:0 are the payload. The sequencer then runs a fixed frame:

- It pulls the shared active-low reset line low.
- It shifts the payload out on the shared data line, most significant bit first.
- It sends one load strobe on the selected channel, or on all channels for code 15.
- It releases the reset line.

The busy flag covers the whole frame. A sticky register records each channel that has received a strobe. Feedback registers keep a copy of the bits that were sent.

When no frame is running and serial mode is off, the data line carries a registered copy of the trigger input. In the same condition the reset line follows the reset input. Every output register changes on the falling clock edge. The synchronous reset is active high and is sampled on that same edge. It forces the safe levels: data low, reset line high, strobes low.

Top module: `serprog_seq`

## Requirements
- R1: While `rst` is high, at each falling edge `sd_out` becomes 0, `nrst_out` becomes 1, and `sload`, `sent`, `fb_hi`, `fb_mid` and `fb_lo` all become 0. `busy` reads 0 as long as `rst` is high.
- R2: A start is accepted when `start` is high, `serial_mode` is high and no frame is running. When that happens, `busy` goes high at once, in the same clock period, without waiting for a clock edge. It stays high until the falling edge that releases the reset line, and is low afterwards.
- R3: At the first falling edge after an accepted start, `nrst_out` goes low. It stays low for exactly 23 clock periods. It is released at the 23rd falling edge that follows that first edge.
- R4: During the 20 clock periods that follow falling edges 1 to 20 of the frame, `sd_out` carries payload bits 19 down to 0, one bit per period. In every other period of the frame, `sd_out` is 0.
- R5: For a channel code c from 0 to 14, `sload[c]` is high for exactly one clock period, the one that follows falling edge 21 of the frame. All other strobes stay low.
- R6: Channel code 15 drives all 15 `sload` bits high together for that same single period.
- R7: `sent[c]` is set at the edge where `sload[c]` rises, and it holds until cleared. A high `sent_clr` clears the whole register at the next falling edge. If a clear and a strobe meet at the same edge, the strobe's bits stay set.
- R8: After a frame, the feedback registers hold the payload: `fb_hi` holds bits 19:16, `fb_mid` holds bits 15:8 and `fb_lo` holds bits 7:0. They hold no channel bits.
- R9: With no frame running, each falling edge loads `nrst_out` from `nreset_in`. `sd_out` is loaded from `trig_in` when `serial_mode` is low, and is 0 when `serial_mode` is high.
- R10: A start is ignored while `serial_mode` is low. A start is also ignored while a frame is running: the running frame's payload and channel are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the registers update on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_mode | input | 1 | Selects serial programming instead of trigger pass-through |
| start | input | 1 | Requests a programming frame |
| cmd_word | input | 24 | Channel code in bits 23:20 and payload in bits 19:0; sampled when a start is accepted |
| trig_in | input | 1 | Trigger passed to `sd_out` outside serial mode |
| nreset_in | input | 1 | Active-low reset passed to `nrst_out` outside a frame |
| sent_clr | input | 1 | Clears the load-sent record |
| sd_out | output | 1 | Shared serial data / trigger line |
| nrst_out | output | 1 | Shared active-low reset line |
| sload | output | 15 | Per-channel serial-load strobes |
| busy | output | 1 | High while a frame is running |
| sent | output | 15 | Sticky record of the strobes that were sent |
| fb_hi | output | 4 | Feedback copy of payload bits 19:16 |
| fb_mid | output | 8 | Feedback copy of payload bits 15:8 |
| fb_lo | output | 8 | Feedback copy of payload bits 7:0 |

## Verification
The hardest case to reach from the ports is a second start that arrives in the middle of a frame. It must leave the running channel and payload alone, which is why `cmd_word` is changed at the same moment. The stimulus raises `start` again five clocks into a frame, with a different word, and then compares the feedback and the sent record against the first word only. A broadcast frame and a start given with serial mode off round out the corner cases. A behavioural model built on a bit queue follows every falling edge, and its values are compared with all of the outputs on every clock.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

    localparam int NCH       = 15;
    localparam int PW        = 20;
    localparam int CW        = 4;
    localparam int WW        = PW + CW;
    localparam int FRAME_LEN = PW + 3;
    localparam int CNTW      = $clog2(FRAME_LEN);

    typedef struct packed {
        logic [CW-1:0] chan;
        logic [PW-1:0] payload;
    } cmd_word_t;

    typedef struct packed {
        logic start_now;
        logic shift;
        logic load_on;
        logic load_off;
        logic finish;
        logic stay;
    } frame_ctl_t;

    function automatic logic [NCH-1:0] chan_mask(input logic [CW-1:0] code);
        logic [NCH-1:0] m;
        m = '0;
        if (code == {CW{1'b1}}) begin
            m = {NCH{1'b1}};
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (code == CW'(i)) m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/serprog_frame_ctrl.sv
module serprog_frame_ctrl
    import serprog_pkg::*;
#(
    parameter int PAYLOAD_W = PW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       serial_mode,
    output frame_ctl_t ctl,
    output logic       active,
    output logic       busy
);
    localparam int CW_L = $clog2(PAYLOAD_W + 3);
    localparam logic [CW_L-1:0] LOAD_AT = CW_L'(PAYLOAD_W);
    localparam logic [CW_L-1:0] DROP_AT = CW_L'(PAYLOAD_W + 1);
    localparam logic [CW_L-1:0] END_AT  = CW_L'(PAYLOAD_W + 2);

    logic            active_q;
    logic [CW_L-1:0] cnt_q;
    logic            accept;

    assign accept = start & serial_mode & ~active_q;

    always_comb begin
        ctl.start_now = accept;
        ctl.shift     = active_q && (cnt_q < LOAD_AT);
        ctl.load_on   = active_q && (cnt_q == LOAD_AT);
        ctl.load_off  = active_q && (cnt_q == DROP_AT);
        ctl.finish    = active_q && (cnt_q == END_AT);
        ctl.stay      = accept | (active_q & ~ctl.finish);
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (ctl.finish) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active = active_q;
    assign busy   = ~rst & (active_q | accept);

    // R10: a running frame advances one step per edge and cannot be restarted
    a_r10_frame_advances: assert property (@(negedge clk) disable iff (rst)
        (active_q && !ctl.finish) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));

    // R2: busy stays high until the frame's final edge
    a_r2_busy_held: assert property (@(negedge clk) disable iff (rst)
        (active_q && !ctl.finish) |=> busy);

endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter
    import serprog_pkg::*;
#(
    parameter int PAYLOAD_W = PW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  frame_ctl_t           ctl,
    input  logic [PAYLOAD_W-1:0] payload_in,
    output logic                 bit_now,
    output logic [PAYLOAD_W-1:0] fb_q
);
    logic [PAYLOAD_W-1:0] sh_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            sh_q <= '0;
            fb_q <= '0;
        end else if (ctl.start_now) begin
            sh_q <= payload_in;
        end else if (ctl.shift) begin
            sh_q <= {sh_q[PAYLOAD_W-2:0], 1'b0};
            fb_q <= {fb_q[PAYLOAD_W-2:0], sh_q[PAYLOAD_W-1]};
        end
    end

    assign bit_now = sh_q[PAYLOAD_W-1];

    // R8: feedback only moves while bits are being shifted out
    a_r8_fb_quiet: assert property (@(negedge clk) disable iff (rst)
        (!ctl.shift) |=> $stable(fb_q));

endmodule

// File: rtl/serprog_load_track.sv
module serprog_load_track
    import serprog_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int CODE_W = CW
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ctl_t        ctl,
    input  logic [CODE_W-1:0] chan_in,
    input  logic              sent_clr,
    output logic [N_CH-1:0]   sload,
    output logic [N_CH-1:0]   sent
);
    logic [CODE_W-1:0] chan_q;
    logic [N_CH-1:0]   mask;

    always_ff @(negedge clk) begin
        if (rst)                chan_q <= '0;
        else if (ctl.start_now) chan_q <= chan_in;
    end

    assign mask = N_CH'(chan_mask(CW'(chan_q)));

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic strobe_q;
        logic sent_q;
        always_ff @(negedge clk) begin
            if (rst) begin
                strobe_q <= 1'b0;
                sent_q   <= 1'b0;
            end else begin
                if (ctl.load_on)       strobe_q <= mask[g];
                else if (ctl.load_off) strobe_q <= 1'b0;
                sent_q <= (sent_q & ~sent_clr) | (ctl.load_on & mask[g]);
            end
        end
        assign sload[g] = strobe_q;
        assign sent[g]  = sent_q;
    end

    // R5: a strobe lasts a single clock period
    a_r5_single_period: assert property (@(negedge clk) disable iff (rst)
        (|sload) |=> !(|sload));

    // R6: strobes are one channel or all channels
    a_r6_mask_shape: assert property (@(negedge clk) disable iff (rst)
        ($onehot0(sload) || (&sload)));

    // R7: without a clear no recorded bit is lost
    a_r7_sticky: assert property (@(negedge clk) disable iff (rst)
        (!sent_clr) |=> (($past(sent) & ~sent) == '0));

endmodule

// File: rtl/serprog_seq.sv
module serprog_seq
    import serprog_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            serial_mode,
    input  logic            start,
    input  logic [WW-1:0]   cmd_word,
    input  logic            trig_in,
    input  logic            nreset_in,
    input  logic            sent_clr,
    output logic            sd_out,
    output logic            nrst_out,
    output logic [NCH-1:0]  sload,
    output logic            busy,
    output logic [NCH-1:0]  sent,
    output logic [PW-17:0]  fb_hi,
    output logic [7:0]      fb_mid,
    output logic [7:0]      fb_lo
);
    cmd_word_t  word;
    frame_ctl_t ctl;
    logic       active;
    logic       bit_now;
    logic [PW-1:0] fb;
    logic       sd_q;
    logic       nrst_q;

    assign word = cmd_word_t'(cmd_word);

    serprog_frame_ctrl #(.PAYLOAD_W(PW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .serial_mode(serial_mode),
        .ctl(ctl), .active(active), .busy(busy)
    );

    serprog_shifter #(.PAYLOAD_W(PW)) u_shift (
        .clk(clk), .rst(rst), .ctl(ctl), .payload_in(word.payload),
        .bit_now(bit_now), .fb_q(fb)
    );

    serprog_load_track #(.N_CH(NCH), .CODE_W(CW)) u_load (
        .clk(clk), .rst(rst), .ctl(ctl), .chan_in(word.chan),
        .sent_clr(sent_clr), .sload(sload), .sent(sent)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            sd_q   <= 1'b0;
            nrst_q <= 1'b1;
        end else begin
            if (ctl.shift)      sd_q <= bit_now;
            else if (ctl.stay)  sd_q <= 1'b0;
            else                sd_q <= serial_mode ? 1'b0 : trig_in;
            nrst_q <= ctl.stay ? 1'b0 : nreset_in;
        end
    end

    assign sd_out   = sd_q;
    assign nrst_out = nrst_q;
    assign fb_hi    = fb[PW-1:16];
    assign fb_mid   = fb[15:8];
    assign fb_lo    = fb[7:0];

    // R3: the reset line is held low for as long as a frame runs
    a_r3_hold_low: assert property (@(negedge clk) disable iff (rst)
        active |-> !nrst_out);

    // R4: the bit on the line is the one just recorded in feedback
    a_r4_line_matches_fb: assert property (@(negedge clk) disable iff (rst)
        ctl.shift |=> (sd_out == fb_lo[0]));

    // R1: safe levels whenever reset was sampled
    a_r1_safe_levels: assert property (@(negedge clk)
        $past(rst) |-> (nrst_out && !sd_out && sload == '0));

endmodule

// File: tb/serprog_seq_tb.sv
`timescale 1ns/100ps
module serprog_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        serial_mode = 1'b0;
    logic        start = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        trig_in = 1'b0;
    logic        nreset_in = 1'b1;
    logic        sent_clr = 1'b0;
    logic        sd_out, nrst_out, busy;
    logic [14:0] sload, sent;
    logic [3:0]  fb_hi;
    logic [7:0]  fb_mid, fb_lo;

    always #2.5 clk = ~clk;

    serprog_seq u_dut (
        .clk(clk), .rst(rst), .serial_mode(serial_mode), .start(start),
        .cmd_word(cmd_word), .trig_in(trig_in), .nreset_in(nreset_in),
        .sent_clr(sent_clr), .sd_out(sd_out), .nrst_out(nrst_out),
        .sload(sload), .busy(busy), .sent(sent), .fb_hi(fb_hi),
        .fb_mid(fb_mid), .fb_lo(fb_lo)
    );

    int total = 0;
    int bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated at every falling edge
    logic        m_sd = 0, m_nrst = 1, m_act = 0;
    logic [14:0] m_sload = 0, m_sent = 0;
    logic [19:0] m_fb = 0;
    logic [3:0]  m_ch = 0;
    int          m_ph = 0;
    bit          m_q[$];

    function automatic logic [14:0] mask_of(input logic [3:0] c);
        if (c == 4'd15) return 15'h7fff;
        return 15'(1) << c;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_sd = 0; m_nrst = 1; m_act = 0; m_sload = 0; m_sent = 0;
            m_fb = 0; m_ph = 0; m_q.delete();
        end else begin
            if (sent_clr) m_sent = 0;
            if (!m_act) begin
                if (start && serial_mode) begin
                    m_act = 1; m_ph = 0; m_q.delete();
                    for (int i = 19; i >= 0; i--) m_q.push_back(cmd_word[i]);
                    m_ch = cmd_word[23:20];
                    m_nrst = 0; m_sd = 0;
                end else begin
                    m_sd = serial_mode ? 1'b0 : trig_in;
                    m_nrst = nreset_in;
                end
            end else begin
                if (m_ph < 20) begin
                    bit b;
                    b = m_q.pop_front();
                    m_sd = b;
                    m_fb = {m_fb[18:0], b};
                end else begin
                    m_sd = 0;
                end
                if (m_ph == 20) begin
                    m_sload = mask_of(m_ch);
                    m_sent = m_sent | mask_of(m_ch);
                end
                if (m_ph == 21) m_sload = 0;
                if (m_ph == 22) begin
                    m_act = 0; m_nrst = nreset_in;
                    m_sd = serial_mode ? 1'b0 : trig_in;
                end else begin
                    m_nrst = 0;
                end
                m_ph++;
            end
        end
    end

    // per-clock comparison, away from the falling edge
    int low_cnt = 0;
    int strobe_cnt = 0;
    always @(posedge clk) begin
        #1;
        if (chk_en) begin
            chk("R4 sd_out", 32'(sd_out), 32'(m_sd));
            chk("R3 nrst_out", 32'(nrst_out), 32'(m_nrst));
            chk("R5 sload", 32'(sload), 32'(m_sload));
            chk("R2 busy", 32'(busy), 32'(m_act | (start & serial_mode & ~m_act & ~rst)));
            chk("R7 sent", 32'(sent), 32'(m_sent));
            chk("R8 feedback", 32'({fb_hi, fb_mid, fb_lo}), 32'(m_fb));
            if (!nrst_out) low_cnt++;
            if (|sload) strobe_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic run_cmd(input logic [3:0] ch, input logic [19:0] pl, input bit intrude);
        @(posedge clk);
        low_cnt = 0; strobe_cnt = 0;
        cmd_word = {ch, pl};
        start = 1;
        #1.5;
        chk("R2 busy immediate", 32'(busy), 32'd1);
        @(posedge clk);
        start = 0;
        if (intrude) begin
            tick(4);
            cmd_word = {~ch, ~pl};
            start = 1;
            @(posedge clk);
            start = 0;
        end
        tick(28);
        #2;
        chk("R3 low periods", 32'(low_cnt), 32'd23);
        chk("R5 strobe periods", 32'(strobe_cnt), 32'd1);
        chk("R8 feedback payload", 32'({fb_hi, fb_mid, fb_lo}), 32'(pl));
        chk("R2 busy cleared", 32'(busy), 32'd0);
    endtask

    initial begin
        tick(4);
        #1;
        chk("R1 sd_out", 32'(sd_out), 32'd0);
        chk("R1 nrst_out", 32'(nrst_out), 32'd1);
        chk("R1 sload", 32'(sload), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 sent", 32'(sent), 32'd0);
        chk("R1 feedback", 32'({fb_hi, fb_mid, fb_lo}), 32'd0);
        @(posedge clk);
        rst = 0;
        chk_en = 1;

        // R9: trigger pass-through and reset follow
        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            trig_in = i[0] ^ i[2];
            nreset_in = (i != 5) && (i != 6);
        end
        @(posedge clk);
        trig_in = 1;
        tick(1);
        #1;
        chk("R9 trigger passes", 32'(sd_out), 32'd1);

        // R10: start ignored outside serial mode
        @(posedge clk);
        cmd_word = 24'h3ABCDE;
        start = 1;
        #1.5;
        chk("R10 no busy in trigger mode", 32'(busy), 32'd0);
        @(posedge clk);
        start = 0;
        tick(30);
        chk("R10 nothing sent", 32'(sent), 32'd0);

        // R9: serial mode idle forces data low
        serial_mode = 1;
        tick(2);
        #1;
        chk("R9 serial idle data low", 32'(sd_out), 32'd0);
        trig_in = 0;

        run_cmd(4'd3, 20'hA5F0C, 1'b0);
        chk("R5 channel 3 recorded", 32'(sent), 32'h0008);
        run_cmd(4'd14, 20'h80001, 1'b0);
        chk("R7 sticky two channels", 32'(sent), 32'h4008);
        run_cmd(4'd0, 20'h5A5A5, 1'b1);
        chk("R10 restart ignored", 32'(sent), 32'h4009);

        @(posedge clk);
        sent_clr = 1;
        @(posedge clk);
        sent_clr = 0;
        #1;
        chk("R7 clear", 32'(sent), 32'd0);

        run_cmd(4'd15, 20'hFFFFF, 1'b0);
        chk("R6 broadcast", 32'(sent), 32'h7fff);
        run_cmd(4'd9, 20'h00000, 1'b0);
        chk("R8 zero payload", 32'({fb_hi, fb_mid, fb_lo}), 32'd0);

        // R9: back to trigger mode, reset input follows
        serial_mode = 0;
        nreset_in = 0;
        tick(3);
        #1;
        chk("R9 reset follows input", 32'(nrst_out), 32'd0);
        nreset_in = 1;
        tick(3);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R2 act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule